// File: doc/BRIEF.md
# Crypto Register Permission Guard

This block keeps the access-control metadata of a small crypto register file. Every register carries a 5-bit permission mask that moves along with the register's value as instructions operate on it. When an instruction is issued (opcode, destination index X, source index Y, immediate), the guard checks whether the instruction may run. The check depends on the current heavy-secure flag and on the masks of the operands. One cycle later it answers with either a grant pulse or a fault pulse. On a grant it updates the destination's mask as the opcode defines.

The guard also holds the active key index, a signature-held flag and a sticky heavy-secure flag. It never sees register data. The cipher, multiply and hash engines work beside it and consult its grant. A combinational peek port reads any register's mask. The key index and both flags are also visible at the ports.

Top module: `crypto_acl_guard`

## Requirements
- R1: After reset all masks read 0, the key index is 0, the signature and heavy-secure flags are 0, and neither grant nor fault is high.
- R2: An issue that is sampled at a clock edge gives exactly one of grant or fault, each high for one cycle in the following cycle. A cycle with no issue gives neither. Mask, key and flag updates take effect at the same edge that samples the issue.
- R3: A fault changes no mask, key index or flag. Opcode 9 and every opcode above 0x18 always fault.
- R4: Opcode 0 (nop) and opcodes 5 to 8 (sequencer control) are always granted and change nothing. Opcode 1 (move) is always granted and copies mask(Y) into mask(X).
- R5: Opcodes 2 (stream in) and 4 (random load) are always granted. They set mask(X) to 0x03 in heavy-secure mode and to 0x1F otherwise.
- R6: Opcode 3 (stream out) is granted when heavy-secure with mask(X) bit 1 set, or when not heavy-secure with mask(X)&0x0A nonzero. It changes no mask.
- R7: Opcodes 0xB, 0xD and 0xF (xor, and, gf-multiply) need bit 1 of both mask(X) and mask(Y) in heavy-secure mode. Otherwise they need mask(X)&0x1A nonzero and mask(Y)&0x0A nonzero. On a grant mask(X) becomes mask(Y).
- R8: Opcode 0xC (add immediate) needs mask(X) bit 1 in heavy-secure mode, or mask(X)&0x1A nonzero otherwise. It leaves every mask unchanged.
- R9: Opcodes 0xE, 0x12 and 0x13 (byte reverse, key expand, reverse key expand) are granted only when not heavy-secure and mask(X) bit 4 is set. They copy mask(Y) into mask(X).
- R10: Opcode 0x11 is always granted and makes X the active key index. Opcodes 0x14 and 0x15 (encrypt, decrypt) are always granted and set mask(X) to mask(key) AND mask(Y), using the masks as they stood before the edge.
- R11: Opcode 0xA writes immediate bits [4:0] into mask(X). It is granted only if the new value sets no bit that is clear in the old mask.
- R12: Opcode 0x10 is granted when the immediate is below NUM_SECRETS. It sets mask(X) to the immediate-th 5-bit entry of the SECRET_ACLS parameter, where entry i sits at bits [5i+4:5i]. The defaults are 0x03, 0x13, 0x10 and 0x1F.
- R13: Opcode 0x16 is granted only while secure_boot is high, and it sets both the signature and heavy-secure flags. The heavy-secure flag clears only at reset. Opcode 0x17 needs the signature flag and sets mask(X) to 0x03. Opcode 0x18 needs the signature flag and clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| issue_op | input | 5 | Opcode |
| issue_x | input | IDX_W | Destination register index |
| issue_y | input | IDX_W | Source register index |
| issue_imm | input | IMM_W | Immediate operand |
| secure_boot | input | 1 | Issuer is executing secure boot code |
| peek_idx | input | IDX_W | Register whose mask is shown on peek_acl |
| peek_acl | output | 5 | Current mask of register peek_idx |
| grant | output | 1 | Previous-cycle issue was allowed |
| fault | output | 1 | Previous-cycle issue was refused |
| key_idx | output | IDX_W | Active key register index |
| sig_held | output | 1 | Signature flag |
| heavy_secure | output | 1 | Heavy-secure flag |

## Verification
The assertions assume that `issue_valid`, `secure_boot` and the operand fields are driven to known values and are held through each sampling edge. They also assume that reset is held for at least one edge before the first issue. With the default register count every index value names a real register, so no out-of-range operand can arise. The bench changes all inputs only on the falling edge and starts issuing only after reset is released. It runs directed sequences first and then pseudo-random ones, both before and after the heavy-secure flag is set, so that both permission regimes are covered.

// File: rtl/crypto_acl_guard.sv
module crypto_acl_guard #(
  parameter int NUM_REGS    = 8,
  parameter int IMM_W       = 6,
  parameter int NUM_SECRETS = 4,
  parameter logic [NUM_SECRETS*5-1:0] SECRET_ACLS = {5'h1F, 5'h10, 5'h13, 5'h03}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic [4:0]       issue_op,
  input  logic [$clog2(NUM_REGS)-1:0] issue_x,
  input  logic [$clog2(NUM_REGS)-1:0] issue_y,
  input  logic [IMM_W-1:0] issue_imm,
  input  logic             secure_boot,
  input  logic [$clog2(NUM_REGS)-1:0] peek_idx,
  output logic [4:0]       peek_acl,
  output logic             grant,
  output logic             fault,
  output logic [$clog2(NUM_REGS)-1:0] key_idx,
  output logic             sig_held,
  output logic             heavy_secure
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0][4:0] acl_q;
  logic [IDX_W-1:0] key_q;
  logic sig_q, hs_q;

  logic [4:0] ax, ay, ak, new_acl, sec_acl;
  logic ok, wr, set_key, set_sig, clr_sig, pair_ok;

  assign ax = acl_q[issue_x];
  assign ay = acl_q[issue_y];
  assign ak = acl_q[key_q];
  assign peek_acl = acl_q[peek_idx];
  assign key_idx = key_q;
  assign sig_held = sig_q;
  assign heavy_secure = hs_q;

  assign pair_ok = hs_q ? (ax[1] & ay[1]) : ((|(ax & 5'h1A)) & (|(ay & 5'h0A)));

  always_comb begin
    sec_acl = '0;
    for (int i = 0; i < NUM_SECRETS; i++)
      if (int'(issue_imm) == i) sec_acl = SECRET_ACLS[i*5 +: 5];
  end

  always_comb begin
    ok = 1'b0; wr = 1'b0; new_acl = ax;
    set_key = 1'b0; set_sig = 1'b0; clr_sig = 1'b0;
    case (issue_op)
      5'h00, 5'h05, 5'h06, 5'h07, 5'h08: ok = 1'b1;
      5'h01: begin ok = 1'b1; wr = 1'b1; new_acl = ay; end
      5'h02, 5'h04: begin ok = 1'b1; wr = 1'b1; new_acl = hs_q ? 5'h03 : 5'h1F; end
      5'h03: ok = hs_q ? ax[1] : |(ax & 5'h0A);
      5'h0A: begin ok = (issue_imm[4:0] & ~ax) == 5'h0; wr = 1'b1; new_acl = issue_imm[4:0]; end
      5'h0B, 5'h0D, 5'h0F: begin ok = pair_ok; wr = 1'b1; new_acl = ay; end
      5'h0C: ok = hs_q ? ax[1] : |(ax & 5'h1A);
      5'h0E, 5'h12, 5'h13: begin ok = !hs_q && ax[4]; wr = 1'b1; new_acl = ay; end
      5'h10: begin ok = int'(issue_imm) < NUM_SECRETS; wr = 1'b1; new_acl = sec_acl; end
      5'h11: begin ok = 1'b1; set_key = 1'b1; end
      5'h14, 5'h15: begin ok = 1'b1; wr = 1'b1; new_acl = ak & ay; end
      5'h16: begin ok = secure_boot; set_sig = 1'b1; end
      5'h17: begin ok = sig_q; wr = 1'b1; new_acl = 5'h03; end
      5'h18: begin ok = sig_q; clr_sig = 1'b1; end
      default: ok = 1'b0;
    endcase
  end

  wire go = issue_valid && ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acl_q <= '0;
      key_q <= '0;
      sig_q <= 1'b0;
      hs_q  <= 1'b0;
      grant <= 1'b0;
      fault <= 1'b0;
    end else begin
      grant <= go;
      fault <= issue_valid && !ok;
      if (go && wr) acl_q[issue_x] <= new_acl;
      if (go && set_key) key_q <= issue_x;
      if (go && set_sig) begin sig_q <= 1'b1; hs_q <= 1'b1; end
      if (go && clr_sig) sig_q <= 1'b0;
    end
  end

  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> (grant ^ fault)); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> !(grant || fault)); // R2
  AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (acl_q == $past(acl_q) && key_q == $past(key_q)
               && sig_q == $past(sig_q) && hs_q == $past(hs_q))); // R3
  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && (issue_op == 5'h09 || issue_op > 5'h18)) |=> fault); // R3
  AST_HS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hs_q |=> hs_q); // R13
  AST_SIG_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && (issue_op == 5'h17 || issue_op == 5'h18) && !sig_q) |=> fault); // R13
  AST_CHMOD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_op == 5'h0A && (issue_imm[4:0] & ~acl_q[issue_x]) != 5'h0) |=> fault); // R11
  AST_HS_NO_REV: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && hs_q && (issue_op == 5'h0E || issue_op == 5'h12 || issue_op == 5'h13)) |=> fault); // R9
endmodule

// File: tb/sim_crypto_acl_guard.sv
`timescale 1ns/1ps
module sim_crypto_acl_guard;
  logic clk = 0, rst_n = 0;
  logic issue_valid = 0, secure_boot = 0;
  logic [4:0] issue_op = 0;
  logic [2:0] issue_x = 0, issue_y = 0, peek_idx = 0, key_idx;
  logic [5:0] issue_imm = 0;
  logic [4:0] peek_acl;
  logic grant, fault, sig_held, heavy_secure;

  always #10 clk = ~clk;

  crypto_acl_guard u0 (.clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_x(issue_x), .issue_y(issue_y), .issue_imm(issue_imm), .secure_boot(secure_boot),
    .peek_idx(peek_idx), .peek_acl(peek_acl), .grant(grant), .fault(fault),
    .key_idx(key_idx), .sig_held(sig_held), .heavy_secure(heavy_secure));

  int checks = 0, fails = 0;
  int m_acl[8];
  int m_key = 0, m_sig = 0, m_hs = 0;
  int sec_tab[4] = '{'h03, 'h13, 'h10, 'h1F};

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag(int op);
    case (op)
      0, 1, 5, 6, 7, 8: return "R4";
      2, 4: return "R5";
      3: return "R6";
      'hB, 'hD, 'hF: return "R7";
      'hC: return "R8";
      'hE, 'h12, 'h13: return "R9";
      'hA: return "R11";
      'h10: return "R12";
      'h11, 'h14, 'h15: return "R10";
      'h16, 'h17, 'h18: return "R13";
      default: return "R3";
    endcase
  endfunction

  function automatic bit anyb(int v, int m);
    return (v & m) != 0;
  endfunction

  task automatic compare_all(string req);
    for (int i = 0; i < 8; i++) begin
      peek_idx = 3'(i);
      #1;
      chk(req, $sformatf("mask r%0d", i), int'(peek_acl), m_acl[i]);
    end
    chk(req, "key index", int'(key_idx), m_key);
    chk(req, "signature flag", int'(sig_held), m_sig);
    chk(req, "heavy-secure flag", int'(heavy_secure), m_hs);
  endtask

  task automatic issue(int op, int x, int y, int imm, bit sb, bit v = 1'b1);
    int ok, ax, ay, nv, wr;
    string req;
    ok = 0; wr = 0; nv = 0;
    ax = m_acl[x]; ay = m_acl[y];
    if (v) begin
      case (op)
        0, 5, 6, 7, 8: ok = 1;
        1: begin ok = 1; wr = 1; nv = ay; end
        2, 4: begin ok = 1; wr = 1; nv = m_hs ? 'h03 : 'h1F; end
        3: ok = m_hs ? anyb(ax, 2) : anyb(ax, 'hA);
        'hA: begin ok = ((imm & 'h1F) & ~ax) == 0; wr = 1; nv = imm & 'h1F; end
        'hB, 'hD, 'hF: begin
          ok = m_hs ? (anyb(ax, 2) && anyb(ay, 2)) : (anyb(ax, 'h1A) && anyb(ay, 'hA));
          wr = 1; nv = ay;
        end
        'hC: ok = m_hs ? anyb(ax, 2) : anyb(ax, 'h1A);
        'hE, 'h12, 'h13: begin ok = !m_hs && anyb(ax, 'h10); wr = 1; nv = ay; end
        'h10: begin ok = imm < 4; wr = 1; if (imm < 4) nv = sec_tab[imm]; end
        'h11: ok = 1;
        'h14, 'h15: begin ok = 1; wr = 1; nv = m_acl[m_key] & ay; end
        'h16: ok = sb;
        'h17: begin ok = m_sig; wr = 1; nv = 'h03; end
        'h18: ok = m_sig;
        default: ok = 0;
      endcase
    end
    issue_valid = v; issue_op = 5'(op); issue_x = 3'(x); issue_y = 3'(y);
    issue_imm = 6'(imm); secure_boot = sb;
    if (v && ok) begin
      if (wr) m_acl[x] = nv;
      if (op == 'h11) m_key = x;
      if (op == 'h16) begin m_sig = 1; m_hs = 1; end
      if (op == 'h18) m_sig = 0;
    end
    req = !v ? "R2" : (ok ? tag(op) : "R3");
    @(posedge clk);
    @(negedge clk);
    issue_valid = 0;
    chk(v ? tag(op) : "R2", $sformatf("grant op=%0h", op), int'(grant), v && ok);
    chk(v ? tag(op) : "R2", $sformatf("fault op=%0h", op), int'(fault), v && !ok);
    compare_all(req);
  endtask

  task automatic rand_phase(int n, bit allow_sig);
    int ops[25] = '{0,1,2,3,4,5,6,7,8,9,'hA,'hB,'hC,'hD,'hE,'hF,'h10,'h11,'h12,'h13,'h14,'h15,'h17,'h18,'h1C};
    for (int k = 0; k < n; k++) begin
      int op;
      op = ops[$urandom_range(0, 24)];
      if (allow_sig && $urandom_range(0, 40) == 0) op = 'h16;
      issue(op, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 31),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) != 0));
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_acl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", "grant after reset", int'(grant), 0);
    chk("R1", "fault after reset", int'(fault), 0);
    compare_all("R1");
    issue(0, 0, 0, 0, 0, 1'b0);
    issue(3, 0, 0, 0, 0);
    issue(0, 0, 0, 0, 0);
    issue(6, 1, 2, 3, 0);
    for (int i = 0; i < 4; i++) issue(2, i, 0, 0, 0);
    issue(4, 4, 0, 0, 0);
    issue(1, 5, 0, 0, 0);
    issue('hA, 1, 0, 'h0A, 0);
    issue('hA, 1, 0, 'h1A, 0);
    issue('hA, 2, 0, 'h10, 0);
    issue('hA, 3, 0, 'h00, 0);
    issue(3, 1, 0, 0, 0);
    issue(3, 2, 0, 0, 0);
    issue('hB, 0, 1, 0, 0);
    issue('hD, 2, 1, 0, 0);
    issue('hF, 3, 0, 0, 0);
    issue('hC, 4, 0, 5, 0);
    issue('hC, 3, 0, 5, 0);
    issue('hE, 4, 2, 0, 0);
    issue('h12, 2, 1, 0, 0);
    issue('h13, 5, 6, 0, 0);
    issue('h11, 1, 0, 0, 0);
    issue('h14, 6, 5, 0, 0);
    issue('h15, 7, 1, 0, 0);
    for (int i = 0; i < 5; i++) issue('h10, i, 0, i, 0);
    issue(9, 0, 0, 0, 0);
    issue('h1F, 0, 0, 0, 0);
    issue('h17, 0, 0, 0, 0);
    issue('h18, 0, 0, 0, 0);
    issue('h16, 0, 0, 0, 0);
    rand_phase(400, 1'b0);
    issue('h16, 0, 0, 0, 1);
    issue(2, 0, 0, 0, 0);
    issue(4, 1, 0, 0, 0);
    issue(3, 0, 0, 0, 0);
    issue('hB, 0, 1, 0, 0);
    issue('hA, 2, 0, 0, 0);
    issue('hB, 0, 2, 0, 0);
    issue('hC, 1, 0, 1, 0);
    issue('hE, 3, 1, 0, 0);
    issue('h17, 4, 0, 0, 0);
    issue('h18, 0, 0, 0, 0);
    issue('h17, 5, 0, 0, 0);
    rand_phase(400, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule